// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small fully associative cache of address translations in which every slot carries a context tag (a virtual-processor identifier) next to its virtual page number and physical frame number. The monitor that hosts the guests always runs with tag 0. Each guest context has its own nonzero tag. A lookup presents a virtual page together with the currently active tag, and it resolves in the same cycle to a hit with a frame, or to a miss.

New translations come from an external page walker through a fill port. A fill refreshes a slot that already holds the same tag and page. Failing that, it takes the lowest-numbered empty slot. When no slot is empty, it evicts the slot named by a rotating pointer. Because every slot is tagged, a switch between contexts does not need to empty the whole cache. A selective flush clears only the slots of one tag in a single cycle, and translations that belong to other contexts stay usable. A global flush is also provided, and it clears every slot whatever its tag.

Top module: `vtlb_top`

## Requirements
- R1: After a synchronous reset every slot is empty, so every requested lookup reports a miss and no hit.
- R2: A requested lookup whose tag and page both equal those of a valid slot raises `lk_hit` and drives that slot's frame on `lk_pfn` in the same cycle, with no register in between. A translation that is filled is visible from the next cycle.
- R3: A lookup matches only slots whose tag equals `lk_id`. The same page held under another tag, including tag 0 for the monitor, gives a miss.
- R4: When `lk_req` is high and no slot matches, `lk_miss` is 1 and `lk_pfn` is 0. When `lk_req` is low, both `lk_hit` and `lk_miss` are 0 and `lk_pfn` is 0.
- R5: A fill that matches no existing slot writes the valid lowest-indexed empty slot.
- R6: When all 16 slots are valid, a fill that matches no existing slot replaces the slot at a rotating pointer. The pointer starts at 0 after reset, advances by one for each such eviction, and wraps from 15 back to 0.
- R7: A fill whose tag and page equal those of a valid slot overwrites the frame of that slot. It never creates a second copy, so at most one slot can match any lookup.
- R8: A selective flush clears, in one cycle, exactly the slots whose tag equals `flush_sel_id`. Slots with any other tag keep their contents.
- R9: A global flush empties every slot in one cycle, whatever its tag.
- R10: A fill that arrives in the same cycle as a selective flush of the same tag is dropped. A fill with a different tag in that cycle is performed.
- R11: A fill in the same cycle as a global flush is dropped.
- R12: Tag 0 is handled like any other tag. Flushing tag 0 removes only the translations of the monitor, and flushing a guest tag leaves those of the monitor in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_id | input | 16 | Active context tag for the lookup |
| lk_vpn | input | 20 | Virtual page to translate |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup requested and not found |
| lk_pfn | output | 20 | Physical frame on a hit, zero otherwise |
| fill_en | input | 1 | Install a translation |
| fill_id | input | 16 | Tag of the translation to install |
| fill_vpn | input | 20 | Page of the translation to install |
| fill_pfn | input | 20 | Frame of the translation to install |
| flush_sel_en | input | 1 | Clear all slots of one tag |
| flush_sel_id | input | 16 | Tag to clear |
| flush_all | input | 1 | Clear every slot |

## Verification
The hardest state to reach is a full cache that has holes in the middle. A fill must then pick a hole in the middle instead of the rotating victim, and later evictions have to follow a pointer that holes have skipped. The stimulus fills all slots with two alternating tags and flushes one of them, which leaves every odd slot empty. It then refills, overflows past the wrap of the pointer, and runs fills and flushes of the same tag in the same cycle. A reference model in the bench is compared with the lookup outputs on every clock, and a long random phase with few tags and pages forces frequent refreshes, collisions and overlaps of the flush controls.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    parameter int unsigned VT_ENTRIES = 16;
    parameter int unsigned VT_ID_W    = 16;
    parameter int unsigned VT_VPN_W   = 20;
    parameter int unsigned VT_PFN_W   = 20;

    localparam int unsigned VT_IDX_W = $clog2(VT_ENTRIES);
    localparam int unsigned VT_LAST  = VT_ENTRIES - 1;

    typedef logic [VT_ID_W-1:0]    vt_id_t;
    typedef logic [VT_VPN_W-1:0]   vt_vpn_t;
    typedef logic [VT_PFN_W-1:0]   vt_pfn_t;
    typedef logic [VT_IDX_W-1:0]   vt_idx_t;
    typedef logic [VT_ENTRIES-1:0] vt_vec_t;

    // lookup / fill key: context tag plus page
    typedef struct packed {
        vt_id_t  id;
        vt_vpn_t vpn;
    } vt_key_t;

    // one translation slot
    typedef struct packed {
        logic    valid;
        vt_key_t key;
        vt_pfn_t pfn;
    } vt_entry_t;

    typedef vt_entry_t [VT_ENTRIES-1:0] vt_array_t;

    // how a fill obtains its slot
    typedef enum logic [1:0] {
        SLOT_REFRESH = 2'd0,
        SLOT_FREE    = 2'd1,
        SLOT_EVICT   = 2'd2
    } vt_slot_e;

    // index of the lowest set bit (0 when none set)
    function automatic vt_idx_t lowest_set(input vt_vec_t v);
        vt_idx_t r;
        r = '0;
        for (int i = VT_ENTRIES - 1; i >= 0; i--) begin
            if (v[i]) r = vt_idx_t'(i);
        end
        return r;
    endfunction

    function automatic vt_idx_t ptr_next(input vt_idx_t p);
        return (p == vt_idx_t'(VT_LAST)) ? '0 : p + vt_idx_t'(1);
    endfunction

endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
(
    input  vt_array_t ents,
    input  vt_key_t   key,
    output vt_vec_t   match_vec
);
    for (genvar g = 0; g < VT_ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ents[g].valid && (ents[g].key == key);
    end
endmodule

// File: rtl/vtlb_victim.sv
module vtlb_victim
    import vtlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  vt_vec_t  valid_vec,
    input  vt_vec_t  same_key_vec,
    input  logic     fill_go,
    output vt_idx_t  slot_idx,
    output vt_slot_e slot_kind
);
    vt_idx_t rr_ptr;

    always_comb begin
        if (|same_key_vec) begin
            slot_kind = SLOT_REFRESH;
            slot_idx  = lowest_set(same_key_vec);
        end else if (!(&valid_vec)) begin
            slot_kind = SLOT_FREE;
            slot_idx  = lowest_set(~valid_vec);
        end else begin
            slot_kind = SLOT_EVICT;
            slot_idx  = rr_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (fill_go && slot_kind == SLOT_EVICT) begin
            rr_ptr <= ptr_next(rr_ptr);
        end
    end

    // R6
    rr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_go && slot_kind == SLOT_EVICT) |=> (rr_ptr == ptr_next($past(rr_ptr))));
endmodule

// File: rtl/vtlb_store.sv
module vtlb_store
    import vtlb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fill_go,
    input  vt_idx_t   fill_idx,
    input  vt_key_t   fill_key,
    input  vt_pfn_t   fill_pfn,
    input  logic      flush_sel_en,
    input  vt_id_t    flush_sel_id,
    input  logic      flush_all,
    output vt_array_t ents,
    output vt_vec_t   valid_vec
);
    for (genvar g = 0; g < VT_ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else begin
                if (flush_all) begin
                    ents[g].valid <= 1'b0;
                end else if (flush_sel_en && ents[g].key.id == flush_sel_id) begin
                    ents[g].valid <= 1'b0;
                end
                if (fill_go && fill_idx == vt_idx_t'(g)) begin
                    ents[g].valid <= 1'b1;
                    ents[g].key   <= fill_key;
                    ents[g].pfn   <= fill_pfn;
                end
            end
        end
        assign valid_vec[g] = ents[g].valid;
    end

    // checker state: remembers the last selective flush
    logic    sel_q;
    vt_id_t  sel_id_q;
    vt_vec_t stale_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            sel_id_q <= '0;
        end else begin
            sel_q    <= flush_sel_en;
            sel_id_q <= flush_sel_id;
        end
    end

    for (genvar g = 0; g < VT_ENTRIES; g++) begin : g_stale
        assign stale_vec[g] = ents[g].valid && ents[g].key.id == sel_id_q;
    end

    // R8 / R10
    sel_flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        sel_q |-> (stale_vec == '0));

    // R9 / R11
    global_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_vec == '0));
endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
    import vtlb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_req,
    input  logic [VT_ID_W-1:0]  lk_id,
    input  logic [VT_VPN_W-1:0] lk_vpn,
    output logic                lk_hit,
    output logic                lk_miss,
    output logic [VT_PFN_W-1:0] lk_pfn,
    input  logic                fill_en,
    input  logic [VT_ID_W-1:0]  fill_id,
    input  logic [VT_VPN_W-1:0] fill_vpn,
    input  logic [VT_PFN_W-1:0] fill_pfn,
    input  logic                flush_sel_en,
    input  logic [VT_ID_W-1:0]  flush_sel_id,
    input  logic                flush_all
);
    vt_array_t ents;
    vt_vec_t   valid_vec;
    vt_vec_t   lk_vec;
    vt_vec_t   fill_vec;
    vt_key_t   lk_key;
    vt_key_t   fill_key;
    vt_idx_t   slot_idx;
    vt_slot_e  slot_kind;
    logic      fill_go;
    logic      fill_blocked;

    assign lk_key   = '{id: lk_id,   vpn: lk_vpn};
    assign fill_key = '{id: fill_id, vpn: fill_vpn};

    // flush wins over a conflicting fill
    assign fill_blocked = flush_all || (flush_sel_en && flush_sel_id == fill_id);
    assign fill_go      = fill_en && !fill_blocked;

    vtlb_match u_lk_match (
        .ents      (ents),
        .key       (lk_key),
        .match_vec (lk_vec)
    );

    vtlb_match u_fill_match (
        .ents      (ents),
        .key       (fill_key),
        .match_vec (fill_vec)
    );

    vtlb_victim u_victim (
        .clk          (clk),
        .rst          (rst),
        .valid_vec    (valid_vec),
        .same_key_vec (fill_vec),
        .fill_go      (fill_go),
        .slot_idx     (slot_idx),
        .slot_kind    (slot_kind)
    );

    vtlb_store u_store (
        .clk          (clk),
        .rst          (rst),
        .fill_go      (fill_go),
        .fill_idx     (slot_idx),
        .fill_key     (fill_key),
        .fill_pfn     (fill_pfn),
        .flush_sel_en (flush_sel_en),
        .flush_sel_id (flush_sel_id),
        .flush_all    (flush_all),
        .ents         (ents),
        .valid_vec    (valid_vec)
    );

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < VT_ENTRIES; i++) begin
            if (lk_vec[i]) lk_pfn = lk_pfn | ents[i].pfn;
        end
        if (!lk_req) lk_pfn = '0;
    end

    assign lk_hit  = lk_req && (|lk_vec);
    assign lk_miss = lk_req && !(|lk_vec);

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec));

    // R2
    fill_visible_chk: assert property (@(posedge clk) disable iff (rst)
        fill_go ##1 (lk_req && lk_id == $past(fill_id) && lk_vpn == $past(fill_vpn)
                     && !$past(fill_blocked))
        |-> (lk_hit && lk_pfn == $past(fill_pfn)));
endmodule

// File: tb/tb_vtlb_top.sv
module tb_vtlb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [15:0] lk_id = '0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit, lk_miss;
    logic [19:0] lk_pfn;
    logic        fill_en = 1'b0;
    logic [15:0] fill_id = '0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        flush_sel_en = 1'b0;
    logic [15:0] flush_sel_id = '0;
    logic        flush_all = 1'b0;

    always #5 clk = ~clk;

    vtlb_top dut (
        .clk(clk), .rst(rst),
        .lk_req(lk_req), .lk_id(lk_id), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
        .fill_en(fill_en), .fill_id(fill_id), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .flush_sel_en(flush_sel_en), .flush_sel_id(flush_sel_id), .flush_all(flush_all)
    );

    // reference model
    bit m_v[16];
    int m_id[16];
    int m_vpn[16];
    int m_pfn[16];
    int m_rr;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_v[i] = 0;
        m_rr = 0;
    endtask

    task automatic compare();
        bit exp_hit = 0;
        int exp_pfn = 0;
        bit exp_miss;
        for (int i = 0; i < 16; i++)
            if (m_v[i] && m_id[i] == int'(lk_id) && m_vpn[i] == int'(lk_vpn)) begin
                exp_hit = 1; exp_pfn = m_pfn[i];
            end
        if (!lk_req) begin exp_hit = 0; exp_pfn = 0; end
        exp_miss = lk_req && !exp_hit;
        checks++;
        if (lk_hit !== exp_hit || lk_miss !== exp_miss || int'(lk_pfn) != exp_pfn) begin
            errors++;
            $display("FAIL %s: id=%0d vpn=%0d got hit=%0b miss=%0b pfn=%0h expected hit=%0b miss=%0b pfn=%0h",
                     tag, lk_id, lk_vpn, lk_hit, lk_miss, lk_pfn, exp_hit, exp_miss, exp_pfn);
        end
    endtask

    task automatic model_update();
        bit go;
        int slot = -1;
        go = fill_en && !flush_all && !(flush_sel_en && flush_sel_id == fill_id);
        if (go) begin
            for (int i = 0; i < 16; i++)
                if (slot < 0 && m_v[i] && m_id[i] == int'(fill_id) && m_vpn[i] == int'(fill_vpn)) slot = i;
            for (int i = 0; i < 16; i++)
                if (slot < 0 && !m_v[i]) slot = i;
            if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % 16; end
        end
        for (int i = 0; i < 16; i++)
            if (flush_all || (flush_sel_en && m_id[i] == int'(flush_sel_id))) m_v[i] = 0;
        if (go) begin
            m_v[slot] = 1; m_id[slot] = int'(fill_id);
            m_vpn[slot] = int'(fill_vpn); m_pfn[slot] = int'(fill_pfn);
        end
    endtask

    // one clock: outputs compared before the edge, model follows the edge
    task automatic tick();
        #1 compare();
        @(posedge clk);
        if (rst) model_reset(); else model_update();
        @(negedge clk);
        fill_en = 0; flush_sel_en = 0; flush_all = 0; lk_req = 0;
    endtask

    task automatic look(input int id, input int vpn);
        lk_req = 1; lk_id = 16'(id); lk_vpn = 20'(vpn);
        tick();
    endtask

    task automatic fill(input int id, input int vpn, input int pfn);
        fill_en = 1; fill_id = 16'(id); fill_vpn = 20'(vpn); fill_pfn = 20'(pfn);
        tick();
    endtask

    task automatic probe_all(input int id, input int nvpn);
        for (int v = 0; v < nvpn; v++) look(id, v);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1; tick(); tick();
        rst = 0;

        tag = "R1";
        probe_all(0, 4); probe_all(7, 4);

        tag = "R2";
        fill(0, 1, 'h111); look(0, 1);
        fill(0, 2, 'h222); fill(0, 3, 'h333);
        probe_all(0, 5);
        lk_req = 1; lk_id = 0; lk_vpn = 2; tick();

        tag = "R3";
        fill(5, 1, 'h551);
        look(0, 1); look(5, 1); look(5, 2); look(9, 1);

        tag = "R4";
        lk_req = 0; lk_id = 0; lk_vpn = 1; tick();
        look(0, 99);

        tag = "R7";
        fill(0, 1, 'h777); look(0, 1); look(5, 1);

        tag = "R8";
        flush_sel_en = 1; flush_sel_id = 5; tick();
        look(5, 1); look(0, 1); look(0, 2);

        tag = "R12";
        fill(3, 1, 'h3a1);
        flush_sel_en = 1; flush_sel_id = 0; tick();
        probe_all(0, 4); look(3, 1);
        fill(0, 8, 'h808);
        flush_sel_en = 1; flush_sel_id = 3; tick();
        look(0, 8); look(3, 1);

        tag = "R9";
        flush_all = 1; tick();
        probe_all(0, 9);

        tag = "R5";
        for (int i = 0; i < 16; i++) fill(1 + (i % 2), i, 'h100 + i);
        flush_sel_en = 1; flush_sel_id = 2; tick();
        fill(4, 40, 'h440); fill(4, 41, 'h441);
        probe_all(1, 16); look(4, 40); look(4, 41);

        tag = "R6";
        flush_all = 1; tick();
        for (int i = 0; i < 16; i++) fill(6, i, 'h600 + i);
        for (int i = 0; i < 20; i++) begin
            fill(6, 100 + i, 'h700 + i);
            look(6, i % 16);
        end
        probe_all(6, 16);

        tag = "R10";
        fill_en = 1; fill_id = 6; fill_vpn = 200; fill_pfn = 'h9;
        flush_sel_en = 1; flush_sel_id = 6; tick();
        look(6, 200);
        fill_en = 1; fill_id = 7; fill_vpn = 201; fill_pfn = 'hab;
        flush_sel_en = 1; flush_sel_id = 8; tick();
        look(7, 201);

        tag = "R11";
        fill_en = 1; fill_id = 7; fill_vpn = 202; fill_pfn = 'hcd;
        flush_all = 1; tick();
        look(7, 202); look(7, 201);

        tag = "R2/R5/R6/R7/R8";
        for (int n = 0; n < 3000; n++) begin
            lk_req = $urandom_range(0, 3) != 0;
            lk_id = 16'($urandom_range(0, 3)); lk_vpn = 20'($urandom_range(0, 7));
            fill_en = $urandom_range(0, 1);
            fill_id = 16'($urandom_range(0, 3)); fill_vpn = 20'($urandom_range(0, 7));
            fill_pfn = 20'($urandom_range(0, 'hfffff));
            flush_sel_en = $urandom_range(0, 15) == 0;
            flush_sel_id = 16'($urandom_range(0, 3));
            flush_all = $urandom_range(0, 127) == 0;
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule